// File: doc/BRIEF.md
# Saturating Fractional Multiply-Accumulate Unit

This block multiplies two signed 16-bit Q15 operands and returns a 32-bit word in one of two formats. In the default format the word is the full signed product, read as Q1.30. In the doubled format the word is shifted left by one to give Q31. A saturation enable picks what happens when a value cannot be represented. Either the word clamps to the nearest rail, or it wraps. An overflow flag reports the condition in both cases. The unit also returns a 16-bit Q15 value taken from the top half of the word, truncated or rounded.

An accumulate enable adds each product to a running Q1.30 sum that is held with guard bits. The sum is never doubled while it builds up. Range checking and the optional doubling are applied only when the sum is turned into the output word. A clear input restarts the sum.

Operands enter on a valid/ready stream and results leave on another. A beat is accepted when `s_valid` and `s_ready` are both high. `s_ready` is high when the single output register is empty or is being drained in the same cycle, so back-pressure on `m_ready` stalls the input stream. The format, saturation, rounding and accumulate controls are sampled together with the accepted beat. `acc_clr` acts in every cycle.

Top module: `qfrac_mac`

## Requirements
- R1: After reset, `m_valid` is 0, `s_ready` is 1 and the running sum is zero, so the first accumulating beat returns its own product.
- R2: A beat is taken when `s_valid && s_ready`, and `s_ready` equals `!m_valid || m_ready`. The result of a beat shows on `m_word`, `m_q15` and `m_ovf` with `m_valid` high in the cycle after it is taken. These outputs hold steady while `m_valid && !m_ready`. Results leave in the order the beats were taken.
- R3: With `q31_sel`=0 and `acc_en`=0, `m_word` is the signed 32-bit product (Q1.30) and `m_ovf` is 0.
- R4: With `q31_sel`=1 and `acc_en`=0, `m_word` is the product shifted left by one bit (Q31), provided the product lies in [-0x40000000, 0x3FFFFFFF].
- R5: With `q31_sel`=1 and `sat_en`=1, 0x8000 times 0x8000 gives `m_word`=0x7FFFFFFF and `m_ovf`=1.
- R6: With `q31_sel`=1 and `sat_en`=0, 0x8000 times 0x8000 gives `m_word`=0x80000000 and `m_ovf`=1.
- R7: With `acc_en`=1, the product is added to a 40-bit signed Q1.30 sum. The beat's output is the new sum, converted in the selected format.
- R8: Conversion of a value V: in Q31 format V overflows outside [-0x40000000, 0x3FFFFFFF], and in Q1.30 format outside [-0x80000000, 0x7FFFFFFF]. When V overflows with `sat_en`=1, the word is 0x7FFFFFFF for positive V and 0x80000000 for negative V. Otherwise the word is the low 32 bits of 2V (Q31) or of V (Q1.30).
- R9: `m_ovf` is 1 exactly when the value overflows as in R8, whatever `sat_en` is.
- R10: `acc_clr`=1 discards the sum in any cycle and takes priority over accumulation. On an accumulating beat with `acc_clr`=1 the new sum equals that beat's product.
- R11: With `round_en`=0, `m_q15` is `m_word[31:16]`. With `round_en`=1, `m_word[15]` is added to that value, except that 0x7FFF stays 0x7FFF.
- R12: A beat with `acc_en`=0 and `acc_clr`=0 leaves the running sum unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat can be taken |
| s_op_a | input | 16 | Q15 operand A |
| s_op_b | input | 16 | Q15 operand B |
| q31_sel | input | 1 | 1: doubled Q31 word, 0: Q1.30 word |
| sat_en | input | 1 | Clamp on overflow instead of wrapping |
| round_en | input | 1 | Round the Q15 output instead of truncating |
| acc_en | input | 1 | Add the product to the running sum |
| acc_clr | input | 1 | Discard the running sum |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Downstream takes the result |
| m_word | output | 32 | 32-bit result word |
| m_q15 | output | 16 | Q15 value from the upper half of the word |
| m_ovf | output | 1 | The value did not fit the selected format |

## Verification
A corrupted running sum has no effect at the ports until the next accumulating beat. It then shows at once in `m_word`, and in `m_ovf` when it crosses a range limit. For this reason the sequences interleave plain beats, clears with and without a beat, and idle cycles with accumulation. A wrong range test or rail value shows only at the extreme operands and sums, in the same cycle as the result. A fault in the handshake register shows as a lost, repeated or reordered result while `m_ready` is toggled.

// File: rtl/qfrac_pkg.sv
package qfrac_pkg;

  // Conversion controls sampled with each accepted beat
  typedef struct packed {
    logic q31;   // double the value into Q31
    logic sat;   // clamp instead of wrap
    logic rnd;   // round the upper half
  } conv_ctl_t;

endpackage

// File: rtl/qfrac_mul.sv
module qfrac_mul #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0]   op_a,
  input  logic signed [DW-1:0]   op_b,
  output logic signed [2*DW-1:0] prod
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] a_x, b_x;

  // Full-width product: the most negative square still fits in Q1.30
  always_comb begin
    a_x  = {{DW{op_a[DW-1]}}, op_a};
    b_x  = {{DW{op_b[DW-1]}}, op_b};
    prod = a_x * b_x;
  end
endmodule

// File: rtl/qfrac_acc.sv
module qfrac_acc #(
  parameter int PW = 32,
  parameter int AW = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 acc_en,
  input  logic                 acc_clr,
  input  logic signed [PW-1:0] prod,
  output logic signed [AW-1:0] val
);
  localparam int GW = AW - PW;

  logic signed [AW-1:0] acc_q, base, prod_x, sum;

  always_comb begin
    prod_x = {{GW{prod[PW-1]}}, prod};
    base   = acc_clr ? '0 : acc_q;
    sum    = base + prod_x;
    val    = acc_en ? sum : prod_x;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               acc_q <= '0;
    else if (take && acc_en)  acc_q <= sum;
    else if (acc_clr)         acc_q <= '0;
  end

  // R10: a clear without an accumulating beat empties the sum
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr && !(take && acc_en) |=> acc_q == '0);

  // R12: without clear or accumulation the sum keeps its value
  assert_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_clr && !(take && acc_en) |=> $stable(acc_q));
endmodule

// File: rtl/qfrac_norm.sv
module qfrac_norm
  import qfrac_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic signed [AW-1:0]  val,
  input  conv_ctl_t             ctl,
  output logic [2*DW-1:0]       word,
  output logic [DW-1:0]         q15,
  output logic                  ovf
);
  localparam int RW = 2 * DW;
  localparam logic [DW-1:0] Q15_MAX = {1'b0, {(DW-1){1'b1}}};

  logic [AW-RW:0]   top_w;   // bits that must agree for a Q1.30 word
  logic [AW-RW+1:0] top_d;   // bits that must agree for a doubled word
  logic [RW-1:0]    raw, rail;
  logic [DW-1:0]    hi;
  logic             up;

  always_comb begin
    top_d = val[AW-1:RW-2];
    top_w = val[AW-1:RW-1];
    if (ctl.q31) begin
      ovf = !((&top_d) || (~|top_d));
      raw = {val[RW-2:0], 1'b0};
    end else begin
      ovf = !((&top_w) || (~|top_w));
      raw = val[RW-1:0];
    end
    rail = val[AW-1] ? {1'b1, {(RW-1){1'b0}}} : {1'b0, {(RW-1){1'b1}}};
    word = (ovf && ctl.sat) ? rail : raw;
    hi   = word[RW-1:DW];
    up   = ctl.rnd && word[DW-1];
    q15  = (up && hi != Q15_MAX) ? hi + 1'b1 : hi;
  end
endmodule

// File: rtl/qfrac_mac.sv
module qfrac_mac
  import qfrac_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [DW-1:0]   s_op_a,
  input  logic [DW-1:0]   s_op_b,
  input  logic            q31_sel,
  input  logic            sat_en,
  input  logic            round_en,
  input  logic            acc_en,
  input  logic            acc_clr,
  output logic            m_valid,
  input  logic            m_ready,
  output logic [2*DW-1:0] m_word,
  output logic [DW-1:0]   m_q15,
  output logic            m_ovf
);
  localparam int RW = 2 * DW;
  localparam logic [DW-1:0] OP_MIN  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] Q15_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [RW-1:0] W_MAX   = {1'b0, {(RW-1){1'b1}}};
  localparam logic [RW-1:0] W_MIN   = {1'b1, {(RW-1){1'b0}}};

  logic                 take;
  logic signed [RW-1:0] prod;
  logic signed [AW-1:0] val;
  conv_ctl_t            ctl;
  logic [RW-1:0]        n_word;
  logic [DW-1:0]        n_q15;
  logic                 n_ovf;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;
  assign ctl     = '{q31: q31_sel, sat: sat_en, rnd: round_en};

  qfrac_mul #(.DW(DW)) u_mul (
    .op_a (s_op_a),
    .op_b (s_op_b),
    .prod (prod)
  );

  qfrac_acc #(.PW(RW), .AW(AW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .acc_en  (acc_en),
    .acc_clr (acc_clr),
    .prod    (prod),
    .val     (val)
  );

  qfrac_norm #(.DW(DW), .AW(AW)) u_norm (
    .val  (val),
    .ctl  (ctl),
    .word (n_word),
    .q15  (n_q15),
    .ovf  (n_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_word  <= '0;
      m_q15   <= '0;
      m_ovf   <= 1'b0;
    end else if (take) begin
      m_valid <= 1'b1;
      m_word  <= n_word;
      m_q15   <= n_q15;
      m_ovf   <= n_ovf;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R2: a stalled result stays put
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_word) && $stable(m_q15) && $stable(m_ovf));

  // R2: a taken beat is presented on the next cycle
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> m_valid);

  // R3: a single product read as Q1.30 never overflows
  assert_plain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take && !acc_en && !q31_sel |-> !n_ovf);

  // R5: the lone unrepresentable square clamps to the positive rail
  assert_square_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take && !acc_en && q31_sel && sat_en && s_op_a == OP_MIN && s_op_b == OP_MIN
    |-> n_ovf && n_word == W_MAX);

  // R8: clamped results sit on a rail
  assert_rail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take && sat_en && n_ovf |-> (n_word == W_MAX || n_word == W_MIN));

  // R11: rounding never wraps the positive limit
  assert_q15_clamp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take && n_word[RW-1:DW] == Q15_MAX |-> n_q15 == Q15_MAX);
endmodule

// File: tb/sim_qfrac_mac.sv
`timescale 1ns/1ps
module sim_qfrac_mac;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        s_valid = 0, s_ready;
  logic [15:0] s_op_a = 0, s_op_b = 0;
  logic        q31_sel = 0, sat_en = 0, round_en = 0, acc_en = 0, acc_clr = 0;
  logic        m_valid, m_ready = 1;
  logic [31:0] m_word;
  logic [15:0] m_q15;
  logic        m_ovf;

  int    checks = 0, errors = 0;
  bit    took = 0, rand_ready = 0, done = 0;
  string force_tag = "";
  longint m_acc = 0;

  logic [31:0] qw[$];
  logic [15:0] qq[$];
  bit          qo[$];
  string       qt[$];

  always #2 clk = ~clk;

  qfrac_mac u0 (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic longint wrap40(input longint v);
    longint t;
    t = v <<< 24;
    return t >>> 24;
  endfunction

  always @(negedge clk) if (rand_ready) m_ready <= ($urandom % 10) < 6;
                        else m_ready <= 1'b1;

  // Reference model, evaluated each cycle after inputs settle
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(m_valid == (qw.size() != 0), "R2 valid", m_valid, qw.size() != 0);
      chk(s_ready == (!m_valid || m_ready), "R2 ready", s_ready, !m_valid || m_ready);
      if (m_valid && m_ready && qw.size() != 0) begin
        chk(m_word == qw[0], qt[0], m_word, qw[0]);
        chk(m_q15 == qq[0], "R11", m_q15, qq[0]);
        chk(m_ovf == qo[0], "R9", m_ovf, qo[0]);
        void'(qw.pop_front()); void'(qq.pop_front());
        void'(qo.pop_front()); void'(qt.pop_front());
      end
      took = s_valid && s_ready;
      if (took) begin
        longint p, v;
        bit ov;
        logic [31:0] w;
        logic [15:0] hi, q;
        string tg;
        p = longint'($signed(s_op_a)) * longint'($signed(s_op_b));
        v = acc_en ? wrap40((acc_clr ? 0 : m_acc) + p) : p;
        if (q31_sel) ov = v > 64'sd1073741823 || v < -64'sd1073741824;
        else         ov = v > 64'sd2147483647 || v < -64'sd2147483648;
        if (ov && sat_en) w = (v < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        else              w = q31_sel ? 32'(v * 2) : 32'(v);
        hi = w[31:16];
        q  = (round_en && w[15] && hi != 16'h7FFF) ? hi + 16'd1 : hi;
        if (force_tag != "")        tg = force_tag;
        else if (acc_en && ov)      tg = "R8";
        else if (acc_en)            tg = "R7";
        else if (q31_sel && ov)     tg = sat_en ? "R5" : "R6";
        else if (q31_sel)           tg = "R4";
        else                        tg = "R3";
        qw.push_back(w); qq.push_back(q); qo.push_back(ov); qt.push_back(tg);
        if (acc_en) m_acc = v;
        else if (acc_clr) m_acc = 0;
      end else if (acc_clr) begin
        m_acc = 0;
      end
    end else begin
      took = 0;
    end
  end

  task automatic send(input logic [15:0] a, input logic [15:0] b, input bit q31,
                      input bit sat, input bit acc, input bit clr, input bit rnd,
                      input string tag);
    s_valid = 1; s_op_a = a; s_op_b = b; q31_sel = q31; sat_en = sat;
    acc_en = acc; acc_clr = clr; round_en = rnd; force_tag = tag;
    do @(posedge clk); while (!took);
    @(negedge clk);
    s_valid = 0; acc_clr = 0; force_tag = "";
  endtask

  task automatic idle(input int n, input bit clr);
    s_valid = 0; acc_clr = clr;
    repeat (n) @(negedge clk);
    acc_clr = 0;
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 5)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'h4000 ^ 16'($urandom % 64);
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(m_valid == 1'b0, "R1 valid", m_valid, 0);
    rst_n = 1;
    #1;
    chk(m_valid == 1'b0 && s_ready == 1'b1, "R1 ready", s_ready, 1);
    @(negedge clk);
    // R1: sum starts at zero -> 0x40000000 as Q1.30
    send(16'h8000, 16'h8000, 0, 0, 1, 0, 0, "R1");
    // R3: plain products
    send(16'h4000, 16'h4000, 0, 1, 0, 0, 0, "");
    send(16'h8000, 16'h7FFF, 0, 1, 0, 0, 0, "");
    send(16'h7FFF, 16'h7FFF, 0, 0, 0, 0, 1, "");
    send(16'hFFFF, 16'h0001, 0, 0, 0, 0, 0, "");
    send(16'h8000, 16'h8000, 0, 1, 0, 0, 0, "");
    // R4: doubled products
    send(16'h4000, 16'hC000, 1, 1, 0, 0, 0, "");
    send(16'h7FFF, 16'h7FFF, 1, 0, 0, 0, 1, "");
    send(16'h8000, 16'h7FFF, 1, 0, 0, 0, 0, "");
    // R5 / R6: the special square, R11 clamp on rounding
    send(16'h8000, 16'h8000, 1, 1, 0, 0, 0, "");
    send(16'h8000, 16'h8000, 1, 0, 0, 0, 0, "");
    send(16'h8000, 16'h8000, 1, 1, 0, 0, 1, "R11");
    // R7 / R8: accumulate upward in Q31 and Q1.30
    send(16'h4000, 16'h4000, 1, 1, 1, 1, 0, "R10");
    send(16'h4000, 16'h4000, 1, 1, 1, 0, 0, "");
    send(16'h4000, 16'h4000, 1, 1, 1, 0, 0, "");
    send(16'h4000, 16'h4000, 1, 0, 1, 0, 0, "");
    send(16'h8000, 16'h8000, 0, 0, 1, 0, 0, "");
    send(16'h8000, 16'h8000, 0, 1, 1, 0, 0, "");
    // R8: negative overflow
    send(16'h8000, 16'h7FFF, 0, 1, 1, 1, 0, "R10");
    send(16'h8000, 16'h7FFF, 1, 1, 1, 0, 0, "");
    send(16'h8000, 16'h7FFF, 0, 0, 1, 0, 0, "");
    send(16'h8000, 16'h7FFF, 0, 1, 1, 0, 0, "");
    // R12: non-accumulating beats leave the sum
    send(16'h1000, 16'h1000, 0, 0, 1, 1, 0, "R10");
    send(16'h7FFF, 16'h7FFF, 0, 0, 0, 0, 0, "");
    idle(3, 0);
    send(16'h1000, 16'h1000, 0, 0, 1, 0, 0, "R12");
    // R10: idle clear, and clear on a plain beat
    idle(2, 1);
    send(16'h1000, 16'h1000, 0, 0, 1, 0, 0, "R10");
    send(16'h2000, 16'h2000, 0, 0, 0, 1, 0, "");
    send(16'h1000, 16'h1000, 0, 0, 1, 0, 0, "R10");
    // R2 and the rest: random traffic under back-pressure
    rand_ready = 1;
    for (int i = 0; i < 1500; i++) begin
      bit cl;
      cl = ($urandom % 8) == 0;
      if (($urandom % 6) == 0) idle(1 + $urandom % 3, ($urandom % 4) == 0);
      send(pick(), pick(), $urandom % 2, $urandom % 2, ($urandom % 3) != 0, cl,
           $urandom % 2, "");
    end
    rand_ready = 0;
    repeat (10) @(negedge clk);
    chk(qw.size() == 0, "R2 drain", qw.size(), 0);
    finish_run();
  end
endmodule